// File: doc/BRIEF.md
# Strobe-Selected Link Serializer (Host Side)

This block sits at the host end of a narrow serial link. It watches two parallel strobe inputs and a serial-peripheral style write path that reuses two control lines. On the active edge of whichever source is currently selected, it captures a parallel word. It then sends that word as a framed burst on a serial valid/bit pair, one bit per clock. The link stays quiet between frames.

A write is captured on the rising edge of the active strobe and carries the full word: control bits, the direction bit, the select bit and 18 data bits. A read starts on the falling edge with the direction bit high. It sends only the eight control-class bits. The block then waits for an 18-bit answer on the return pair, drives that answer onto the read data bus, and releases the bus on the host's next rising strobe edge. Strobe edges that arrive while a write frame is still on the wire are dropped and flagged. Strobe edges that arrive while a read is outstanding are ignored without a flag.

Every frame starts with a 1 start bit and a 2-bit type code: 01 write, 10 read request, 11 serial-peripheral write. Next comes the 8-bit class field {ctl[5:0], rw, sel}. Only a write frame carries the 18 data bits after that. All fields go out most significant bit first. The link clock is an input, and all inputs are sampled in that clock domain.

Top module: `strobe_link_master`

## Requirements
- R1: With par_mode_i=1, src_sel_i=0 selects strb0_i and src_sel_i=1 selects strb1_i. With par_mode_i=0 and src_sel_i=1, strb1_i is still used in parallel fashion. Edges on a source that is not selected produce no frame.
- R2: A rising edge of the active strobe with rw_i=0 sends a 29-bit write frame. The bits are start 1, type 01, ctl[5:0], rw, sel and data[17:0], in that order, MSB first, one bit per clock. ser_valid_o is high for exactly the frame length and ser_bit_o is 1 in its first cycle.
- R3: A falling edge of the active strobe with rw_i=1 sends an 11-bit read-request frame: start 1, type 10, ctl[5:0], rw, sel. data_i is not sent.
- R4: With par_mode_i=0 and src_sel_i=0, ctl_i[5] acts as the serial clock and strb0_i as an active-low select. A rising ctl_i[5] edge while strb0_i=0 sends an 11-bit frame of type 11 with the class field. The same edge while strb0_i=1 sends nothing.
- R5: After a read request, an answer on rsp_valid_i/rsp_bit_i (a 1 start bit, then 18 data bits MSB first) is driven on rd_data_o with rd_oe_o=1. rd_oe_o returns to 0 after the next rising edge of the active strobe.
- R6: ser_valid_o and ser_bit_o are 0 after reset and between frames.
- R7: An active strobe edge that arrives while a write or serial-peripheral frame is being sent pulses overrun_o for one clock. The edge is dropped, and no second frame follows.
- R8: From a read request until the answer has been received, strobe edges start no frame and raise no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst | input | 1 | Synchronous active-high reset |
| strb0_i | input | 1 | Strobe 0; active-low select in serial-peripheral mode |
| strb1_i | input | 1 | Strobe 1 |
| src_sel_i | input | 1 | Source select |
| par_mode_i | input | 1 | 1 = parallel mode, 0 = serial-peripheral mode on source 0 |
| rw_i | input | 1 | 1 = read, 0 = write |
| ctl_i | input | 6 | Control bits; [5] serial clock and [4] serial data in serial-peripheral mode |
| data_i | input | 18 | Write data |
| ser_valid_o | output | 1 | High while a frame bit is on ser_bit_o |
| ser_bit_o | output | 1 | Outgoing frame bit |
| rsp_valid_i | input | 1 | Answer frame bit valid |
| rsp_bit_i | input | 1 | Answer frame bit |
| rd_data_o | output | 18 | Read data returned over the link |
| rd_oe_o | output | 1 | Read data bus drive enable |
| overrun_o | output | 1 | One-clock pulse for a dropped strobe edge |

## Verification
The bench loops frames through a behavioural responder and decodes each frame's length and fields. Writes are issued through strobe 0, through strobe 1, and through strobe 1 in serial-peripheral mode. These runs show that the select table is honoured and that an edge on the unselected strobe is ignored. Serial-clock edges are tried with the select line low and high, which shows that the chip-select gating works. A read round trip toggles the strobe while the read is outstanding and then releases the bus. Back-to-back write strobes separate a dropped edge from a queued one.

// File: rtl/link_master_pkg.sv
package link_master_pkg;
    localparam int DW        = 18;
    localparam int CW        = 6;
    localparam int TYPE_W    = 2;
    localparam int HDR_W     = 1 + TYPE_W;
    localparam int CLS_W     = CW + 2;
    localparam int SHORT_LEN = HDR_W + CLS_W;
    localparam int LONG_LEN  = SHORT_LEN + DW;
    localparam int LEN_W     = $clog2(LONG_LEN + 1);
    localparam int RX_W      = $clog2(DW + 1);

    typedef enum logic [TYPE_W-1:0] {
        FT_NONE  = 2'd0,
        FT_WRITE = 2'd1,
        FT_RDREQ = 2'd2,
        FT_SPI   = 2'd3
    } ftype_t;

    typedef struct packed {
        logic [CW-1:0] ctl;
        logic          rw;
        logic          sel;
    } cls_t;

    typedef struct packed {
        cls_t          cls;
        logic [DW-1:0] data;
    } word_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_RD_SEND, ST_RD_WAIT, ST_RD_DRIVE
    } st_t;

    function automatic logic [LONG_LEN-1:0] build_frame(ftype_t t, word_t w);
        logic [DW-1:0] payload;
        payload = (t == FT_WRITE) ? w.data : '0;
        return {1'b1, t, w.cls, payload};
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(ftype_t t);
        return (t == FT_WRITE) ? LEN_W'(LONG_LEN) : LEN_W'(SHORT_LEN);
    endfunction
endpackage

// File: rtl/strobe_front.sv
module strobe_front
    import link_master_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          strb0_i,
    input  logic          strb1_i,
    input  logic          src_sel_i,
    input  logic          par_mode_i,
    input  logic          rw_i,
    input  logic [CW-1:0] ctl_i,
    input  logic [DW-1:0] data_i,
    output word_t         word_o,
    output ftype_t        ev_o,
    output logic          act_rise_o
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] s_strb, p_strb, rise, fall;
    logic            s_sel, s_par, s_rw, p_sck;
    logic [CW-1:0]   s_ctl;
    logic [DW-1:0]   s_data;
    logic            spi_mode, sck_rise, a_rise, a_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_strb <= '0;
            p_strb <= '0;
            s_sel  <= 1'b0;
            s_par  <= 1'b1;
            s_rw   <= 1'b0;
            s_ctl  <= '0;
            s_data <= '0;
            p_sck  <= 1'b0;
        end else begin
            s_strb <= {strb1_i, strb0_i};
            p_strb <= s_strb;
            s_sel  <= src_sel_i;
            s_par  <= par_mode_i;
            s_rw   <= rw_i;
            s_ctl  <= ctl_i;
            s_data <= data_i;
            p_sck  <= s_ctl[CW-1];
        end
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_edge
        assign rise[g] = s_strb[g] & ~p_strb[g];
        assign fall[g] = ~s_strb[g] & p_strb[g];
    end

    assign spi_mode = ~s_par & ~s_sel;
    assign sck_rise = s_ctl[CW-1] & ~p_sck;

    always_comb begin
        if (spi_mode) begin
            a_rise = sck_rise & ~s_strb[0];
            a_fall = 1'b0;
        end else begin
            a_rise = rise[s_sel];
            a_fall = fall[s_sel];
        end
        if (spi_mode)
            ev_o = a_rise ? FT_SPI : FT_NONE;
        else if (a_rise && !s_rw)
            ev_o = FT_WRITE;
        else if (a_fall && s_rw)
            ev_o = FT_RDREQ;
        else
            ev_o = FT_NONE;
    end

    assign act_rise_o   = a_rise;
    assign word_o.cls   = '{ctl: s_ctl, rw: s_rw, sel: s_sel};
    assign word_o.data  = s_data;
endmodule

// File: rtl/frame_tx.sv
module frame_tx
    import link_master_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [LONG_LEN-1:0] frame_i,
    input  logic [LEN_W-1:0]    len_i,
    output logic                valid_o,
    output logic                bit_o
);
    logic [LONG_LEN-1:0] shreg;
    logic [LEN_W-1:0]    cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (load_i) begin
            shreg <= frame_i;
            cnt   <= len_i;
        end else if (cnt != '0) begin
            shreg <= {shreg[LONG_LEN-2:0], 1'b0};
            cnt   <= cnt - 1'b1;
        end
    end

    assign valid_o = (cnt != '0);
    assign bit_o   = valid_o & shreg[LONG_LEN-1];
endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import link_master_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          arm_i,
    input  logic          valid_i,
    input  logic          bit_i,
    output logic          done_o,
    output logic [DW-1:0] data_o
);
    logic [RX_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            data_o <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!arm_i) begin
                cnt <= '0;
            end else if (cnt == '0) begin
                if (valid_i && bit_i)
                    cnt <= RX_W'(DW);
            end else if (valid_i) begin
                data_o <= {data_o[DW-2:0], bit_i};
                cnt    <= cnt - 1'b1;
                if (cnt == RX_W'(1))
                    done_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/strobe_link_master.sv
module strobe_link_master
    import link_master_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          strb0_i,
    input  logic          strb1_i,
    input  logic          src_sel_i,
    input  logic          par_mode_i,
    input  logic          rw_i,
    input  logic [CW-1:0] ctl_i,
    input  logic [DW-1:0] data_i,
    output logic          ser_valid_o,
    output logic          ser_bit_o,
    input  logic          rsp_valid_i,
    input  logic          rsp_bit_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_oe_o,
    output logic          overrun_o
);
    word_t         word;
    ftype_t        ev;
    logic          act_rise, load, rx_done;
    logic [DW-1:0] rx_data;
    st_t           state;

    strobe_front u_front (
        .clk(clk), .rst(rst), .strb0_i(strb0_i), .strb1_i(strb1_i),
        .src_sel_i(src_sel_i), .par_mode_i(par_mode_i), .rw_i(rw_i),
        .ctl_i(ctl_i), .data_i(data_i),
        .word_o(word), .ev_o(ev), .act_rise_o(act_rise)
    );

    assign load = (state == ST_IDLE) && (ev != FT_NONE);

    frame_tx u_tx (
        .clk(clk), .rst(rst), .load_i(load),
        .frame_i(build_frame(ev, word)), .len_i(frame_len(ev)),
        .valid_o(ser_valid_o), .bit_o(ser_bit_o)
    );

    frame_rx u_rx (
        .clk(clk), .rst(rst), .arm_i(state == ST_RD_WAIT),
        .valid_i(rsp_valid_i), .bit_i(rsp_bit_i),
        .done_o(rx_done), .data_o(rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rd_data_o <= '0;
            rd_oe_o   <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            overrun_o <= 1'b0;
            case (state)
                ST_IDLE:
                    if (ev != FT_NONE)
                        state <= (ev == FT_RDREQ) ? ST_RD_SEND : ST_SEND;
                ST_SEND: begin
                    if (ev != FT_NONE)
                        overrun_o <= 1'b1;
                    if (!ser_valid_o)
                        state <= ST_IDLE;
                end
                ST_RD_SEND:
                    if (!ser_valid_o)
                        state <= ST_RD_WAIT;
                ST_RD_WAIT:
                    if (rx_done) begin
                        rd_data_o <= rx_data;
                        rd_oe_o   <= 1'b1;
                        state     <= ST_RD_DRIVE;
                    end
                ST_RD_DRIVE:
                    if (act_rise) begin
                        rd_oe_o <= 1'b0;
                        state   <= ST_IDLE;
                    end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/strobe_link_master_chk.sv
module strobe_link_master_chk
    import link_master_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ser_valid,
    input logic ser_bit,
    input logic rd_oe,
    input logic overrun,
    input st_t  state
);
    // R2
    start_marker_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_valid) |-> ser_bit);

    // R5
    drive_no_tx_chk: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> !ser_valid);

    // R7
    overrun_busy_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(state == ST_SEND));

    // R8
    read_wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_WAIT) |=> !$rose(ser_valid));

    // R6
    idle_link_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE || state == ST_RD_WAIT || state == ST_RD_DRIVE)
        |-> !ser_valid);
endmodule

bind strobe_link_master strobe_link_master_chk u_chk (
    .clk(clk), .rst(rst), .ser_valid(ser_valid_o), .ser_bit(ser_bit_o),
    .rd_oe(rd_oe_o), .overrun(overrun_o), .state(state)
);

// File: tb/tb_strobe_link_master.sv
module tb_strobe_link_master;
    logic clk = 1'b0, rst = 1'b1;
    logic strb0 = 0, strb1 = 0, sel = 0, par = 1, rw = 0;
    logic [5:0]  ctl = '0;
    logic [17:0] data = '0;
    logic ser_valid, ser_bit, rsp_valid = 0, rsp_bit = 0, rd_oe, overrun;
    logic [17:0] rd_data;

    int checks = 0, fails = 0, frames = 0, ovr_cnt = 0, nbits = 0, last_len = 0;
    logic [28:0] buf_q = '0, last_frame = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    strobe_link_master dut (
        .clk(clk), .rst(rst), .strb0_i(strb0), .strb1_i(strb1),
        .src_sel_i(sel), .par_mode_i(par), .rw_i(rw), .ctl_i(ctl),
        .data_i(data), .ser_valid_o(ser_valid), .ser_bit_o(ser_bit),
        .rsp_valid_i(rsp_valid), .rsp_bit_i(rsp_bit), .rd_data_o(rd_data),
        .rd_oe_o(rd_oe), .overrun_o(overrun)
    );

    always @(negedge clk) begin
        if (overrun) ovr_cnt++;
        if (ser_valid) begin
            buf_q = {buf_q[27:0], ser_bit};
            nbits++;
        end else if (nbits > 0) begin
            last_frame = buf_q;
            last_len   = nbits;
            frames++;
            nbits = 0;
            buf_q = '0;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1; cyc(3); s = 0; cyc(3);
    endtask

    function automatic logic [28:0] wr_frame(logic [5:0] c, logic r, logic s, logic [17:0] d);
        return {1'b1, 2'b01, c, r, s, d};
    endfunction

    function automatic logic [28:0] short_frame(logic [1:0] t, logic [5:0] c, logic r, logic s);
        return {18'b0, 1'b1, t, c, r, s};
    endfunction

    task automatic t_reset;
        chk(ser_valid == 0 && ser_bit == 0, "R6 reset link idle", ser_valid, 0);
        chk(rd_oe == 0 && overrun == 0, "R5 reset bus released", rd_oe, 0);
    endtask

    task automatic t_write_src0;
        int f0 = frames;
        par = 1; sel = 0; rw = 0; ctl = 6'h2A; data = 18'h25A5C;
        pulse(strb0); cyc(35);
        chk(frames == f0 + 1, "R1 strobe0 selected makes one frame", frames - f0, 1);
        chk(last_len == 29, "R2 write frame length", last_len, 29);
        chk(last_frame == wr_frame(6'h2A, 0, 0, 18'h25A5C), "R2 write frame fields",
            last_frame, wr_frame(6'h2A, 0, 0, 18'h25A5C));
        chk(ser_valid == 0, "R6 idle after frame", ser_valid, 0);
    endtask

    task automatic t_write_src1;
        int f0 = frames;
        par = 1; sel = 1; rw = 0; ctl = 6'h13; data = 18'h3C0F1;
        pulse(strb0); cyc(35);
        chk(frames == f0, "R1 unselected strobe0 ignored", frames - f0, 0);
        pulse(strb1); cyc(35);
        chk(last_frame == wr_frame(6'h13, 0, 1, 18'h3C0F1), "R1 strobe1 write fields",
            last_frame, wr_frame(6'h13, 0, 1, 18'h3C0F1));
        par = 0; ctl = 6'h05; data = 18'h00FF0;
        pulse(strb1); cyc(35);
        chk(last_len == 29 && last_frame == wr_frame(6'h05, 0, 1, 18'h00FF0),
            "R1 serial mode with select high uses strobe1", last_frame,
            wr_frame(6'h05, 0, 1, 18'h00FF0));
    endtask

    task automatic t_spi;
        int f0;
        par = 0; sel = 0; rw = 0; strb0 = 0; data = 18'h3FFFF;
        ctl = 6'h11; cyc(3);
        f0 = frames;
        ctl[5] = 1; cyc(3); cyc(20);
        chk(frames == f0 + 1 && last_len == 11, "R4 serial clock edge short frame", last_len, 11);
        chk(last_frame == short_frame(2'b11, 6'h31, 0, 0), "R4 serial frame fields",
            last_frame, short_frame(2'b11, 6'h31, 0, 0));
        ctl[5] = 0; cyc(3);
        strb0 = 1; cyc(3);
        f0 = frames;
        ctl[5] = 1; cyc(3); ctl[5] = 0; cyc(20);
        chk(frames == f0, "R4 select high blocks serial clock", frames - f0, 0);
        strb0 = 0; cyc(3);
    endtask

    task automatic t_overrun;
        int f0, o0;
        par = 1; sel = 0; rw = 0; ctl = 6'h3F; data = 18'h12345;
        cyc(3);
        f0 = frames; o0 = ovr_cnt;
        pulse(strb0);
        ctl = 6'h01; data = 18'h00001;
        pulse(strb0); cyc(40);
        chk(ovr_cnt == o0 + 1, "R7 overrun pulsed once", ovr_cnt - o0, 1);
        chk(frames == f0 + 1, "R7 second edge dropped", frames - f0, 1);
        chk(last_frame == wr_frame(6'h3F, 0, 0, 18'h12345), "R7 first word kept",
            last_frame, wr_frame(6'h3F, 0, 0, 18'h12345));
    endtask

    task automatic t_read;
        int f0, o0;
        logic [17:0] ans = 18'h13C5A;
        logic [18:0] pkt;
        par = 1; sel = 0; rw = 1; ctl = 6'h15; data = 18'h2AAAA;
        strb0 = 1; cyc(3);
        f0 = frames; o0 = ovr_cnt;
        strb0 = 0; cyc(25);
        chk(frames == f0 + 1 && last_len == 11, "R3 read request length", last_len, 11);
        chk(last_frame == short_frame(2'b10, 6'h15, 1, 0), "R3 read request fields",
            last_frame, short_frame(2'b10, 6'h15, 1, 0));
        strb0 = 1; cyc(3); strb0 = 0; cyc(3); strb0 = 1; cyc(3); strb0 = 0; cyc(20);
        chk(frames == f0 + 1 && ovr_cnt == o0, "R8 strobes ignored while read outstanding",
            frames - f0, 1);
        chk(rd_oe == 0, "R5 bus not driven before answer", rd_oe, 0);
        pkt = {1'b1, ans};
        for (int i = 18; i >= 0; i--) begin
            rsp_valid = 1; rsp_bit = pkt[i]; cyc(1);
        end
        rsp_valid = 0; rsp_bit = 0; cyc(3);
        chk(rd_oe == 1, "R5 bus driven after answer", rd_oe, 1);
        chk(rd_data == ans, "R5 returned data", rd_data, ans);
        strb0 = 1; cyc(4);
        chk(rd_oe == 0, "R5 bus released on rising strobe", rd_oe, 0);
        chk(frames == f0 + 1, "R5 release edge starts no frame", frames - f0, 1);
        rw = 0; strb0 = 0; cyc(20);
        chk(frames == f0 + 1 && ser_valid == 0, "R6 link quiet after read", frames - f0, 1);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        cyc(4);
        rst = 0;
        cyc(2);
        t_reset();
        t_write_src0();
        t_write_src1();
        t_spi();
        t_overrun();
        t_read();
        summary();
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end
endmodule